// File: doc/BRIEF.md
# Dual Byte FIFO with Programmable Ready Thresholds

This block sits between a host register interface and a serial bus engine and buffers bytes in both directions. The host writes bytes to a transmit queue that the engine drains. The engine deposits received bytes into a receive queue that the host drains. Each direction has a ready output meant to drive a DMA request or an interrupt. A ready only rises once enough room (transmit) or enough data (receive) exists to move a burst of one, two or four bytes, chosen by a small mode register.

The queues can be switched off. In that case each direction collapses to a single holding register, and its ready fires on one entry. Command pulses enable or disable queueing, flush either queue, and return the whole block to its reset condition. When the engine reports a missing acknowledge, the transmit side locks. Queued bytes stay put and nothing is offered to the engine. A later unlock either resumes delivery or, combined with a transmit flush, discards the stale bytes.

Top module: `byte_fifo_pair`

## Requirements
- R1: After hardware reset, queueing is off, both levels are 0, `tx_ready`=1, `rx_ready`=0, `tx_locked`=0 and `mode_rdata`=0.
- R2: With queueing off, each direction holds at most one byte. A second host push or engine put is ignored, and `tx_ready` is 1 only while the transmit side is empty.
- R3: With queueing on, the transmit side holds up to DEPTH bytes and delivers them to the engine in push order. A host push while DEPTH bytes are held is ignored and leaves the level and order unchanged.
- R4: Mode register fields:
  - Bits 1:0 are the transmit threshold code and bits 5:4 are the receive threshold code.
  - Bits 3:2 read back as 0.
  - Code 0 means 1 entry, code 1 means 2, code 2 means 4 and code 3 means 1.
- R5: With queueing on and the side unlocked, `tx_ready` is 1 exactly when the free slots (DEPTH minus `tx_level`) are at least the transmit threshold.
- R6: With queueing on, `rx_ready` is 1 exactly when `rx_level` is at least the receive threshold.
- R7: A host pop updates `host_rx_byte` on the clock edge of the pop. A pop of an empty receive side leaves `host_rx_byte` and `rx_level` unchanged.
- R8: `cmd_tx_flush` empties only the transmit side, `cmd_rx_flush` empties only the receive side, and both may be given in the same cycle.
- R9: Queue enable and disable:
  - `cmd_fifo_on` turns queueing on and `cmd_fifo_off` turns it off.
  - If both are given in the same cycle, off wins.
  - Any change of the on/off state empties both sides.
- R10: `cmd_soft_reset` turns queueing off, empties both sides, clears the lock and zeroes the mode register.
- R11: A pulse on `eng_nack` sets `tx_locked`. While locked:
  - `eng_tx_valid` and `tx_ready` are 0.
  - `eng_tx_take` removes nothing.
  - Host pushes are still accepted.
- R12: `cmd_unlock` clears the lock, and a simultaneous `eng_nack` wins. After an unlock on its own, the kept bytes resume in order. An unlock together with `cmd_tx_flush` leaves the transmit side empty and unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_soft_reset | input | 1 | Return block to reset condition |
| cmd_fifo_on | input | 1 | Enable queueing |
| cmd_fifo_off | input | 1 | Disable queueing |
| cmd_tx_flush | input | 1 | Empty transmit side |
| cmd_rx_flush | input | 1 | Empty receive side |
| cmd_unlock | input | 1 | Clear transmit lock |
| mode_we | input | 1 | Write mode register |
| mode_wdata | input | 6 | Mode write data |
| mode_rdata | output | 6 | Mode readback |
| host_tx_wr | input | 1 | Host push of one byte |
| host_tx_byte | input | DATA_W | Byte pushed by host |
| host_rx_rd | input | 1 | Host pop of one byte |
| host_rx_byte | output | DATA_W | Last byte popped by host |
| eng_tx_take | input | 1 | Engine takes the head transmit byte |
| eng_tx_valid | output | 1 | A transmit byte is offered |
| eng_tx_byte | output | DATA_W | Head transmit byte |
| eng_rx_put | input | 1 | Engine deposits a byte |
| eng_rx_byte | input | DATA_W | Byte deposited by engine |
| eng_nack | input | 1 | Missing acknowledge seen, lock transmit |
| tx_ready | output | 1 | Transmit threshold room available |
| rx_ready | output | 1 | Receive threshold data available |
| tx_level | output | $clog2(DEPTH+1) | Bytes held in transmit side |
| rx_level | output | $clog2(DEPTH+1) | Bytes held in receive side |
| fifo_enabled | output | 1 | Queueing currently on |
| tx_locked | output | 1 | Transmit lock state |

## Verification
The hardest condition to reach is a locked transmit side that still holds bytes. Reaching it needs a full push sequence, then a lock event, then further pushes and engine take attempts. The stimulus queues several bytes at threshold 1 and pulses the acknowledge-failure input. It then pushes more bytes and asserts take against the lock, checking that the level and head stay frozen. It ends with both unlock paths: unlock alone must resume delivery in push order, and unlock with flush must leave an empty, unlocked side. The threshold edges are driven by filling the queue to exactly DEPTH minus the threshold and one beyond. The threshold code is then rewritten while the level is held.

// File: rtl/fifo_thr_pkg.sv
package fifo_thr_pkg;

   typedef enum logic [1:0] {
      THR_ONE  = 2'd0,
      THR_TWO  = 2'd1,
      THR_FOUR = 2'd2,
      THR_RSVD = 2'd3
   } thr_code_e;

   typedef struct packed {
      logic [1:0] rx_code;
      logic [1:0] tx_code;
   } ready_mode_t;

   // entries that a threshold code asks for; reserved code acts as one
   function automatic int unsigned thr_entries(input logic [1:0] code);
      case (thr_code_e'(code))
         THR_TWO:  return 2;
         THR_FOUR: return 4;
         default:  return 1;
      endcase
   endfunction

endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              single,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CW-1:0]     count,
   output logic              full,
   output logic              empty
);

   generate
      if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("fifo_store: DEPTH must be a power of two of at least 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("fifo_store: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic              push_ok, pop_ok;

   assign empty   = (count == '0);
   assign full    = single ? (count != '0) : (count == CW'(DEPTH));
   assign push_ok = push & ~full & ~clear;
   assign pop_ok  = pop & ~empty & ~clear;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R3
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R2
   single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      single |-> count <= CW'(1));
   // R3
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clear) |=> count == $past(count));

endmodule

// File: rtl/thr_ready.sv
module thr_ready
   import fifo_thr_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter bit IS_TX = 1'b1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          fifo_on,
   input  logic [1:0]    code,
   input  logic [CW-1:0] count,
   input  logic          block,
   output logic          ready
);

   logic [CW:0] need;
   logic [CW:0] cap;
   logic [CW:0] held;

   assign need = fifo_on ? (CW+1)'(thr_entries(code)) : (CW+1)'(1);
   assign cap  = fifo_on ? (CW+1)'(DEPTH) : (CW+1)'(1);
   assign held = {1'b0, count};

   generate
      if (IS_TX) begin : g_room
         logic [CW:0] free;
         assign free  = (held >= cap) ? '0 : (cap - held);
         assign ready = ~block & (free >= need);
      end else begin : g_data
         logic unused_block;
         assign unused_block = block;
         assign ready = (held >= need);
      end
   endgenerate

endmodule

// File: rtl/byte_fifo_pair.sv
module byte_fifo_pair
   import fifo_thr_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_soft_reset,
   input  logic              cmd_fifo_on,
   input  logic              cmd_fifo_off,
   input  logic              cmd_tx_flush,
   input  logic              cmd_rx_flush,
   input  logic              cmd_unlock,
   input  logic              mode_we,
   input  logic [5:0]        mode_wdata,
   output logic [5:0]        mode_rdata,
   input  logic              host_tx_wr,
   input  logic [DATA_W-1:0] host_tx_byte,
   input  logic              host_rx_rd,
   output logic [DATA_W-1:0] host_rx_byte,
   input  logic              eng_tx_take,
   output logic              eng_tx_valid,
   output logic [DATA_W-1:0] eng_tx_byte,
   input  logic              eng_rx_put,
   input  logic [DATA_W-1:0] eng_rx_byte,
   input  logic              eng_nack,
   output logic              tx_ready,
   output logic              rx_ready,
   output logic [CW-1:0]     tx_level,
   output logic [CW-1:0]     rx_level,
   output logic              fifo_enabled,
   output logic              tx_locked
);

   ready_mode_t       mode_q;
   logic              on_q, on_d, on_change;
   logic              lock_q;
   logic              tx_clear, rx_clear;
   logic              tx_empty, rx_empty;
   logic              tx_full_unused, rx_full_unused;
   logic              tx_pop, rx_pop_ok;
   logic [DATA_W-1:0] rx_head;
   logic [DATA_W-1:0] rx_last_q;

   // queue enable state: off wins over on, soft reset wins over both
   always_comb begin
      on_d = on_q;
      if (cmd_fifo_on)    on_d = 1'b1;
      if (cmd_fifo_off)   on_d = 1'b0;
      if (cmd_soft_reset) on_d = 1'b0;
   end
   assign on_change = (on_d != on_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) on_q <= 1'b0;
      else        on_q <= on_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              mode_q <= '0;
      else if (cmd_soft_reset) mode_q <= '0;
      else if (mode_we)        mode_q <= '{rx_code: mode_wdata[5:4],
                                          tx_code: mode_wdata[1:0]};
   end
   assign mode_rdata = {mode_q.rx_code, 2'b00, mode_q.tx_code};

   // transmit lock: a new acknowledge failure beats a same-cycle unlock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              lock_q <= 1'b0;
      else if (cmd_soft_reset) lock_q <= 1'b0;
      else if (eng_nack)       lock_q <= 1'b1;
      else if (cmd_unlock)     lock_q <= 1'b0;
   end

   assign tx_clear = cmd_soft_reset | cmd_tx_flush | on_change;
   assign rx_clear = cmd_soft_reset | cmd_rx_flush | on_change;

   assign eng_tx_valid = ~tx_empty & ~lock_q;
   assign tx_pop       = eng_tx_take & eng_tx_valid;

   fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (tx_clear),
      .single(~on_q),
      .push  (host_tx_wr),
      .wdata (host_tx_byte),
      .pop   (tx_pop),
      .head  (eng_tx_byte),
      .count (tx_level),
      .full  (tx_full_unused),
      .empty (tx_empty)
   );

   fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (rx_clear),
      .single(~on_q),
      .push  (eng_rx_put),
      .wdata (eng_rx_byte),
      .pop   (host_rx_rd),
      .head  (rx_head),
      .count (rx_level),
      .full  (rx_full_unused),
      .empty (rx_empty)
   );

   assign rx_pop_ok = host_rx_rd & ~rx_empty & ~rx_clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rx_last_q <= '0;
      else if (rx_pop_ok) rx_last_q <= rx_head;
   end
   assign host_rx_byte = rx_last_q;

   thr_ready #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_tx_ready (
      .fifo_on(on_q),
      .code   (mode_q.tx_code),
      .count  (tx_level),
      .block  (lock_q),
      .ready  (tx_ready)
   );

   thr_ready #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rx_ready (
      .fifo_on(on_q),
      .code   (mode_q.rx_code),
      .count  (rx_level),
      .block  (1'b0),
      .ready  (rx_ready)
   );

   assign fifo_enabled = on_q;
   assign tx_locked    = lock_q;

   // R11
   locked_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_locked |-> !tx_ready);
   // R11
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_locked && !host_tx_wr && !cmd_tx_flush && !cmd_soft_reset &&
       !cmd_fifo_on && !cmd_fifo_off) |=> tx_level == $past(tx_level));
   // R7
   rx_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rx_rd && rx_level == '0) |=> $stable(host_rx_byte));
   // R8
   tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_tx_flush |=> tx_level == '0);
   // R10
   soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_soft_reset |=> (!fifo_enabled && !tx_locked && mode_rdata == '0 &&
                          rx_level == '0));
   // R6
   rx_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_enabled && mode_rdata[5:4] == 2'd2 && rx_level >= CW'(4)) |-> rx_ready);

endmodule

// File: tb/byte_fifo_pair_tb.sv
`timescale 1ns/1ps
module byte_fifo_pair_tb;

   localparam int DEPTH  = 16;
   localparam int DATA_W = 8;
   localparam int CW     = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              cmd_soft_reset = 0, cmd_fifo_on = 0, cmd_fifo_off = 0;
   logic              cmd_tx_flush = 0, cmd_rx_flush = 0, cmd_unlock = 0;
   logic              mode_we = 0;
   logic [5:0]        mode_wdata = '0, mode_rdata;
   logic              host_tx_wr = 0, host_rx_rd = 0;
   logic [DATA_W-1:0] host_tx_byte = '0, host_rx_byte;
   logic              eng_tx_take = 0, eng_tx_valid;
   logic [DATA_W-1:0] eng_tx_byte;
   logic              eng_rx_put = 0, eng_nack = 0;
   logic [DATA_W-1:0] eng_rx_byte = '0;
   logic              tx_ready, rx_ready, fifo_enabled, tx_locked;
   logic [CW-1:0]     tx_level, rx_level;

   byte_fifo_pair #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (.*);

   int n_chk = 0, n_fail = 0;
   logic [7:0] tx_q[$];
   logic [7:0] rx_q[$];
   logic [7:0] last_rx = 8'h00;
   bit en_m = 0, lock_m = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int cap_m();
      return en_m ? DEPTH : 1;
   endfunction

   // driver: host push, predicts acceptance into the scoreboard
   task automatic host_push(input logic [7:0] b);
      @(negedge clk);
      host_tx_wr = 1; host_tx_byte = b;
      if (tx_q.size() < cap_m()) tx_q.push_back(b);
      @(negedge clk);
      host_tx_wr = 0;
   endtask

   // monitor: engine take, compares offered byte with scoreboard head
   task automatic eng_take(input string tag);
      @(negedge clk);
      if (tx_q.size() > 0 && !lock_m) begin
         chk({tag, " valid"}, eng_tx_valid, 1);
         chk({tag, " order"}, eng_tx_byte, tx_q.pop_front());
      end else begin
         chk({tag, " no valid"}, eng_tx_valid, 0);
      end
      eng_tx_take = 1;
      @(negedge clk);
      eng_tx_take = 0;
   endtask

   task automatic eng_put(input logic [7:0] b);
      @(negedge clk);
      eng_rx_put = 1; eng_rx_byte = b;
      if (rx_q.size() < cap_m()) rx_q.push_back(b);
      @(negedge clk);
      eng_rx_put = 0;
   endtask

   task automatic host_pop(input string tag);
      @(negedge clk);
      host_rx_rd = 1;
      if (rx_q.size() > 0) last_rx = rx_q.pop_front();
      @(negedge clk);
      host_rx_rd = 0;
      chk({tag, " rx byte"}, host_rx_byte, last_rx);
   endtask

   task automatic set_mode(input logic [5:0] m);
      @(negedge clk);
      mode_we = 1; mode_wdata = m;
      @(negedge clk);
      mode_we = 0;
   endtask

   task automatic levels(input string tag);
      chk({tag, " tx level"}, tx_level, tx_q.size());
      chk({tag, " rx level"}, rx_level, rx_q.size());
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: cmd_soft_reset = 1;
         1: cmd_fifo_on = 1;
         2: cmd_fifo_off = 1;
         3: cmd_tx_flush = 1;
         4: cmd_rx_flush = 1;
         5: begin cmd_tx_flush = 1; cmd_rx_flush = 1; end
         6: cmd_unlock = 1;
         7: begin cmd_unlock = 1; cmd_tx_flush = 1; end
         8: eng_nack = 1;
         9: begin cmd_fifo_on = 1; cmd_fifo_off = 1; end
         default: ;
      endcase
      @(negedge clk);
      {cmd_soft_reset, cmd_fifo_on, cmd_fifo_off, cmd_tx_flush,
       cmd_rx_flush, cmd_unlock, eng_nack} = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 enabled", fifo_enabled, 0);
      levels("R1");
      chk("R1 tx_ready", tx_ready, 1);
      chk("R1 rx_ready", rx_ready, 0);
      chk("R1 locked", tx_locked, 0);
      chk("R1 mode", mode_rdata, 0);

      // R2 single holding register when disabled
      host_push(8'hA5);
      chk("R2 tx_ready full", tx_ready, 0);
      host_push(8'h3C);
      levels("R2 second push");
      eng_take("R2 take");
      chk("R2 tx_ready empty", tx_ready, 1);
      eng_put(8'h11);
      eng_put(8'h22);
      levels("R2 second put");
      chk("R2 rx_ready", rx_ready, 1);
      host_pop("R2 pop");
      chk("R2 rx_ready empty", rx_ready, 0);

      // R9 enable
      pulse(1); en_m = 1;
      chk("R9 enabled", fifo_enabled, 1);
      // R4 field readback
      set_mode(6'h3F);
      chk("R4 readback", mode_rdata, 6'h33);
      set_mode(6'h22);

      // R5 transmit threshold of four
      for (int i = 0; i < 12; i++) host_push(8'h50 + 8'(i));
      chk("R5 free4 ready", tx_ready, 1);
      host_push(8'h5C);
      chk("R5 free3 not ready", tx_ready, 0);
      for (int i = 13; i < 16; i++) host_push(8'h50 + 8'(i));
      host_push(8'hEE);
      chk("R3 full push ignored", tx_level, DEPTH);
      eng_take("R3 take");
      chk("R5 free1 code2", tx_ready, 0);
      set_mode(6'h23);
      chk("R4 code3 means one", tx_ready, 1);
      set_mode(6'h21);
      chk("R5 free1 code1", tx_ready, 0);
      eng_take("R3 take");
      chk("R5 free2 code1", tx_ready, 1);
      for (int i = 0; i < 14; i++) eng_take("R3 drain");
      levels("R3 drained");

      // R6 receive threshold of four, then two
      set_mode(6'h20);
      for (int i = 0; i < 3; i++) eng_put(8'h70 + 8'(i));
      chk("R6 three of four", rx_ready, 0);
      eng_put(8'h73);
      chk("R6 four of four", rx_ready, 1);
      set_mode(6'h10);
      chk("R6 four of two", rx_ready, 1);
      for (int i = 0; i < 3; i++) host_pop("R6 pop");
      chk("R6 one of two", rx_ready, 0);
      host_pop("R7 last pop");
      host_pop("R7 empty pop");
      levels("R7 empty");

      // R8 flushes
      set_mode(6'h00);
      for (int i = 0; i < 3; i++) host_push(8'h80 + 8'(i));
      eng_put(8'h90); eng_put(8'h91);
      pulse(3); tx_q.delete();
      levels("R8 tx flush only");
      host_push(8'h84);
      pulse(5); tx_q.delete(); rx_q.delete();
      levels("R8 both flush");

      // R11 lock
      for (int i = 0; i < 3; i++) host_push(8'h41 + 8'(i));
      pulse(8); lock_m = 1;
      chk("R11 locked", tx_locked, 1);
      chk("R11 valid low", eng_tx_valid, 0);
      chk("R11 ready low", tx_ready, 0);
      host_push(8'h44);
      eng_take("R11 take blocked");
      levels("R11 held");

      // R12 unlock resumes, unlock with flush empties
      pulse(6); lock_m = 0;
      chk("R12 unlocked", tx_locked, 0);
      eng_take("R12 resume");
      levels("R12 after resume");
      pulse(8); lock_m = 1;
      pulse(7); lock_m = 0; tx_q.delete();
      chk("R12 unlock flush lock", tx_locked, 0);
      levels("R12 unlock flush");
      chk("R12 ready", tx_ready, 1);

      // R9 disable empties, both-at-once stays off
      eng_put(8'hB1); host_push(8'hB2);
      pulse(2); en_m = 0; tx_q.delete(); rx_q.delete();
      chk("R9 disabled", fifo_enabled, 0);
      levels("R9 disable empties");
      pulse(9);
      chk("R9 off wins", fifo_enabled, 0);
      pulse(1); en_m = 1;

      // R10 soft reset
      set_mode(6'h21);
      host_push(8'hC1); eng_put(8'hC2);
      pulse(8); lock_m = 1;
      pulse(0); en_m = 0; lock_m = 0; tx_q.delete(); rx_q.delete();
      chk("R10 enabled", fifo_enabled, 0);
      chk("R10 locked", tx_locked, 0);
      chk("R10 mode", mode_rdata, 0);
      levels("R10");
      chk("R10 tx_ready", tx_ready, 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule